// File: doc/BRIEF.md
# Serial Write-Only Control Register Slave

This block receives two-wire serial writes (I2C bus, write direction only) and loads them into a bank of ten 8-bit control registers. Both bus lines come in as ordinary inputs and are oversampled by the system clock. The block finds start and stop conditions and compares the first byte with a fixed device address. It then reads a subaddress byte and writes the data bytes that follow. The register contents come out as one flat vector. When the block acknowledges a byte, it asserts an output that enables an open-drain pull-down on the data line.

The subaddress holds a register pointer and a flag that selects one of two write patterns. With the flag clear, every data byte up to the stop lands in the same register. With the flag set, the pointer steps forward after each byte, and writes that fall on unused pointer values are dropped. The block still acknowledges those bytes. After reset the bank holds fixed values. These select the first input, maximum input attenuation, both output attenuators muted, surround off and a flat tone response.

Top module: `ctlw_ctrl_slave`

## Requirements
- R1: After reset the register slots hold, by index: 0 = 8'hFF, 1 = 8'h7E, 2 = 8'h00, 3 = 8'h1F, 4 = 8'h7E, 5 = 8'h58, 6 = 8'h58, 7 = 8'h00, 8 = 8'h00, 9 = 8'h06. Slot k occupies regs_o[8k+7:8k].
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on the rising edge of SCL, most significant bit first, eight bits to a byte.
- R3: The block acknowledges only the address byte 8'h80 (address 7'h40 with the write bit 0). After any other first byte it leaves SDA released and writes nothing until the next start.
- R4: An acknowledge drives sda_pull high after the SCL fall that ends the eighth bit. It holds sda_pull through the ninth SCL high period and drops it on the following SCL fall. At all other times sda_pull is low.
- R5: In the subaddress byte, bit 7 is the increment flag, bits 3..0 are the register pointer, and bits 6..4 are ignored.
- R6: With the increment flag clear, every data byte of the transfer is written to the register that the pointer selects.
- R7: With the increment flag set, the first data byte goes to the selected register. The pointer then moves up by one after each data byte and wraps from 15 to 0.
- R8: Data bytes that fall on pointer values 7, 8 or 10 through 15 change no register and are still acknowledged.
- R9: A register changes only once all eight bits of its data byte have been received. A start that arrives partway through a byte drops that byte and restarts address reception.
- R10: After a stop the block ignores SCL activity and writes nothing until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset that loads the power-on values |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND) |
| sda_pull | output | 1 | High enables the external pull-down on SDA for an acknowledge |
| regs_o | output | 80 | Flat register bank, slot k at bits 8k+7..8k |

## Verification
The assertions assume that SCL stays high or low for several system clocks, so that every bus edge passes through the synchronizer and is seen exactly once. They also assume SDA changes only while SCL is low, except for deliberate start and stop conditions. The bench drives both lines at least ten clocks apart, on falling clock edges. It changes data only in the middle of the SCL low phase and models the bus as a wired-AND of the master's drive and the block's pull-down. As a result, the acknowledge is never confused with a start or a stop.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned PTR_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // power-on content of each slot
  function automatic logic [REG_W-1:0] power_on_value(int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'h7E;
      3:       return 8'h1F;
      4:       return 8'h7E;
      5, 6:    return 8'h58;
      9:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  // slot accepts bus data: inside the bank and not one of the two reserved slots
  function automatic logic slot_writable(logic [PTR_W-1:0] ptr, int unsigned nregs);
    return (32'(ptr) < nregs) && (ptr != 4'd7) && (ptr != 4'd8);
  endfunction

  function automatic logic [PTR_W-1:0] advance_ptr(logic [PTR_W-1:0] ptr, logic inc);
    return inc ? ptr + 4'd1 : ptr;
  endfunction
endpackage

// File: rtl/ctlw_sync.sv
module ctlw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctlw_bus_rx.sv
module ctlw_bus_rx
  import ctlw_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h40,
  parameter int unsigned NUM_REGS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data,
  output logic             sda_pull
);
  logic             scl_q, sda_q;
  logic             scl_rise, scl_fall, byte_done, active;
  logic [3:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [7:0]       rx_byte;
  logic [PTR_W-1:0] ptr;
  logic             inc, ack_ok;
  phase_t           phase;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign active    = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);
  assign byte_done = active && scl_rise && (bit_cnt == 4'd7) && !start_evt && !stop_evt;
  assign rx_byte   = {shreg, sda_s};

  assign wr_en   = byte_done && (phase == PH_DATA) && slot_writable(ptr, NUM_REGS);
  assign wr_idx  = ptr;
  assign wr_data = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr      <= '0;
      inc      <= 1'b0;
      ack_ok   <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_evt) begin
        phase    <= PH_ADDR;
        bit_cnt  <= '0;
        ack_ok   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        phase    <= PH_IDLE;
        bit_cnt  <= '0;
        ack_ok   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8) shreg <= {shreg[5:0], sda_s};
          if (bit_cnt != 4'd9) bit_cnt <= bit_cnt + 4'd1;
          if (byte_done) begin
            case (phase)
              PH_ADDR: begin
                ack_ok <= (rx_byte == {DEV_ADDR, 1'b0});
                phase  <= (rx_byte == {DEV_ADDR, 1'b0}) ? PH_SUB : PH_SKIP;
              end
              PH_SUB: begin
                ack_ok <= 1'b1;
                inc    <= rx_byte[7];
                ptr    <= rx_byte[PTR_W-1:0];
                phase  <= PH_DATA;
              end
              default: begin
                ack_ok <= 1'b1;
                ptr    <= advance_ptr(ptr, inc);
              end
            endcase
          end
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            sda_pull <= ack_ok;
          end else if (bit_cnt == 4'd9) begin
            sda_pull <= 1'b0;
            ack_ok   <= 1'b0;
            bit_cnt  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctlw_regbank.sv
module ctlw_regbank
  import ctlw_pkg::*;
#(
  parameter int unsigned NUM_REGS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_o[g*REG_W +: REG_W] <= power_on_value(g);
      else if (wr_en && (wr_idx == PTR_W'(g))) regs_o[g*REG_W +: REG_W] <= wr_data;
    end
  end
endmodule

// File: rtl/ctlw_ctrl_slave.sv
module ctlw_ctrl_slave
  import ctlw_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h40,
  parameter int unsigned NUM_REGS    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_in,
  input  logic                      sda_in,
  output logic                      sda_pull,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic             scl_s, sda_s;
  logic             start_evt, stop_evt, wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;

  ctlw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  ctlw_bus_rx #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull)
  );

  ctlw_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/ctlw_ctrl_slave_chk.sv
module ctlw_ctrl_slave_chk #(
  parameter int unsigned NUM_REGS = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  wr_en,
  input logic                  sda_pull,
  input logic [NUM_REGS*8-1:0] regs_o
);
  AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R4

  AST_PULL_DROPS_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> ($past(!scl_s) || $past(start_evt) || $past(stop_evt))); // R4

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull); // R10

  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R9

  AST_COMMIT_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_s); // R9

  AST_START_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !wr_en); // R9

  if (NUM_REGS > 8) begin : g_holes
    AST_RESERVED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs_o[7*8 +: 16])); // R8
  end
endmodule

bind ctlw_ctrl_slave ctlw_ctrl_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .wr_en(wr_en), .sda_pull(sda_pull), .regs_o(regs_o)
);

// File: tb/ctlw_ctrl_slave_test.sv
module ctlw_ctrl_slave_test;
  localparam int NREG = 10;
  localparam int Q    = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_pull;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0, failures = 0, printed = 0;
  bit hold_cmp = 1, done = 0;
  logic [7:0] exp_regs [NREG];

  always #2 clk = ~clk;

  ctlw_ctrl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .regs_o(regs_o)
  );

  function automatic bit bench_legal(int p);
    return (p >= 0 && p <= 6) || p == 9;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock (R1 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && !hold_cmp && !done) begin
      for (int i = 0; i < NREG; i++) begin
        checks++;
        if (regs_o[i*8 +: 8] !== exp_regs[i]) begin
          failures++;
          if (printed < 10) begin
            printed++;
            $display("FAIL R6/model slot %0d: actual=%0h expected=%0h", i, regs_o[i*8 +: 8], exp_regs[i]);
          end
        end
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wait_n(Q); scl_m = 1; wait_n(Q); sda_m = 0; wait_n(Q); scl_m = 0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_n(Q); scl_m = 1; wait_n(Q); sda_m = 1; wait_n(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_n(Q); scl_m = 1; wait_n(Q); scl_m = 0; wait_n(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, int slot, string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(Q); scl_m = 1;
      if (i == 0) begin
        hold_cmp = 1; wait_n(6);
        if (slot >= 0) exp_regs[slot] = b;
        hold_cmp = 0;
        check(sda_pull == 1'b0, "R4 no early pull", int'(sda_pull), 0);
        wait_n(Q - 6);
      end else wait_n(Q);
      scl_m = 0; wait_n(Q);
    end
    sda_m = 1; wait_n(Q); scl_m = 1; wait_n(Q / 2);
    check(sda_line == !exp_ack, {tag, " ack"}, int'(sda_line), int'(!exp_ack));
    wait_n(Q / 2); scl_m = 0; wait_n(8);
    check(sda_pull == 1'b0, "R4 release", int'(sda_pull), 0);
    wait_n(Q - 8);
  endtask

  task automatic write_txn(logic [7:0] sub, logic [7:0] data[$]);
    int p = sub & 15;
    bit inc = sub[7];
    bus_start();
    send_byte(8'h80, 1, -1, "R2 R3 address");
    send_byte(sub, 1, -1, "R5 subaddress");
    foreach (data[k]) begin
      send_byte(data[k], 1, bench_legal(p) ? p : -1, "R8 data");
      if (inc) p = (p + 1) % 16;
    end
    bus_stop();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r1_vals [NREG] = '{8'hFF, 8'h7E, 8'h00, 8'h1F, 8'h7E, 8'h58, 8'h58, 8'h00, 8'h00, 8'h06};
    logic [7:0] q[$];
    foreach (r1_vals[i]) exp_regs[i] = r1_vals[i];
    wait_n(5); rst_n = 1; wait_n(5);
    // R1 reset values
    for (int i = 0; i < NREG; i++)
      check(regs_o[i*8 +: 8] == r1_vals[i], "R1 power-on", int'(regs_o[i*8 +: 8]), int'(r1_vals[i]));
    hold_cmp = 0;

    // R5 R6: flag clear, don't-care bits set, three bytes to slot 3
    q = '{8'h11, 8'h22, 8'h33};
    write_txn(8'h73, q);
    check(regs_o[3*8 +: 8] == 8'h33, "R6 same slot", int'(regs_o[3*8 +: 8]), 8'h33);

    // R7 R8: increment from 5, through 7,8 and 10..15, wrap to 0,1
    q = '{8'hA5, 8'hA6, 8'hE7, 8'hE8, 8'hA9, 8'hEA, 8'hEB, 8'hEC, 8'hED, 8'hEE, 8'hEF, 8'hB0, 8'hB1};
    write_txn(8'h85, q);
    check(regs_o[5*8 +: 8] == 8'hA5, "R7 first slot", int'(regs_o[5*8 +: 8]), 8'hA5);
    check(regs_o[9*8 +: 8] == 8'hA9, "R7 step", int'(regs_o[9*8 +: 8]), 8'hA9);
    check(regs_o[0 +: 8] == 8'hB0, "R7 wrap", int'(regs_o[0 +: 8]), 8'hB0);
    check(regs_o[1*8 +: 8] == 8'hB1, "R7 after wrap", int'(regs_o[1*8 +: 8]), 8'hB1);
    check(regs_o[7*8 +: 8] == 8'h00, "R8 slot 7 dropped", int'(regs_o[7*8 +: 8]), 0);

    // R8: flag clear on reserved slot 8
    q = '{8'h5A, 8'h5B};
    write_txn(8'h08, q);
    check(regs_o[8*8 +: 8] == 8'h00, "R8 slot 8 dropped", int'(regs_o[8*8 +: 8]), 0);

    // R3: foreign address and read bit
    bus_start();
    send_byte(8'h82, 0, -1, "R3 foreign address");
    send_byte(8'h00, 0, -1, "R3 no ack sub");
    send_byte(8'h44, 0, -1, "R3 no ack data");
    bus_stop();
    bus_start();
    send_byte(8'h81, 0, -1, "R3 read bit");
    send_byte(8'h02, 0, -1, "R3 no ack sub");
    bus_stop();
    check(regs_o[0 +: 8] == 8'hB0, "R3 unchanged", int'(regs_o[0 +: 8]), 8'hB0);

    // R9: start in mid-byte aborts that byte
    bus_start();
    send_byte(8'h80, 1, -1, "R9 address");
    send_byte(8'h04, 1, -1, "R9 sub");
    send_bits(8'h12, 4);
    bus_start();
    send_byte(8'h80, 1, -1, "R9 readdress");
    send_byte(8'h02, 1, -1, "R9 new sub");
    send_byte(8'h3C, 1, 2, "R9 data");
    bus_stop();
    check(regs_o[4*8 +: 8] == 8'h7E, "R9 aborted byte", int'(regs_o[4*8 +: 8]), 8'h7E);
    check(regs_o[2*8 +: 8] == 8'h3C, "R9 restart write", int'(regs_o[2*8 +: 8]), 8'h3C);

    // R10: clocking after stop without a start
    send_byte(8'h80, 0, -1, "R10 idle address");
    send_byte(8'h09, 0, -1, "R10 idle sub");
    send_byte(8'h99, 0, -1, "R10 idle data");
    check(regs_o[9*8 +: 8] == 8'hA9, "R10 no write", int'(regs_o[9*8 +: 8]), 8'hA9);

    wait_n(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule